// File: doc/BRIEF.md
# Leaf Page Entry Access Checker

This block sits at the end of a page-table walk. It receives the final leaf entry, a flag that says whether the access runs in privileged state, and the kind of access: data load, data store or instruction fetch. It decides whether the access may go ahead. If it may not, it reports one of two faults:

- a permission fault;
- a reference/change fault, raised when the entry's tracking bits do not yet allow the access.

It also reports the memory attribute held in the entry.

The decision logic is combinational. One register stage follows it, so every result appears one clock after the request together with a valid strobe. The caller presents one request per cycle, and only in cycles where `valid_i` is high. Updating the tracking bits in memory is left to the caller.

Top module: `pte_access_check`

## Requirements
- R1: The entry's privileged-only flag is bit 3. When that bit is set and `priv_i` is low, permission is denied whatever the other bits hold. When `priv_i` is high, or bit 3 is clear, permission follows R2 or R3.
- R2: A data access is one with `iside_i` low. It is permitted when the read/write bit 1 is set. It is also permitted when the read bit 2 is set and `store_i` is low.
- R3: An instruction fetch is one with `iside_i` high, and `store_i` is then ignored. It is permitted only when the execute bit 0 is set and bit 5 (cache-inhibited) is clear. Bits 1 and 2 play no part in a fetch.
- R4: The tracking check passes when the reference bit 8 is set. A data store additionally needs the change bit 7 to be set.
- R5: `ok_o` is high when both permission and the tracking check pass. `perm_err_o` is high when permission fails. `rc_err_o` is high only when permission passes and the tracking check fails. At most one of the three is high at a time.
- R6: `attr_o` carries entry bits 5:4 with this encoding: 0 normal memory, 1 strongly ordered, 2 non-idempotent I/O, 3 tolerant I/O.
- R7: Each result, and `valid_o`, appears exactly one clock edge after the request is sampled with `valid_i` high.
- R8: A cycle sampled with `valid_i` low gives `valid_o`, `ok_o`, `perm_err_o`, `rc_err_o` and `attr_o` all at 0 after the next edge.
- R9: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A request is present this cycle |
| pte_i | input | PTE_W | Leaf entry, bit 0 is the LSB |
| priv_i | input | 1 | Access runs in privileged state |
| store_i | input | 1 | Data access is a write |
| iside_i | input | 1 | Access is an instruction fetch |
| valid_o | output | 1 | Results below belong to the request of the previous cycle |
| ok_o | output | 1 | Access allowed |
| perm_err_o | output | 1 | Permission fault |
| rc_err_o | output | 1 | Reference/change fault |
| attr_o | output | 2 | Memory attribute from entry bits 5:4 |

## Verification
Every result of this block is due one edge after its request, because a single register stage sits between the inputs and the outputs. The bench therefore changes inputs on a falling edge. It then lets exactly one rising edge pass and compares all five outputs on the following falling edge, before it drives anything new. The check for a cycle with the strobe low uses the same timing: the idle cycle is sampled one edge after it is driven, and a faulting entry stays on the inputs during that cycle.

// File: rtl/pte_acc_pkg.sv
package pte_acc_pkg;
  // Leaf entry bit positions (LSB-0)
  localparam int unsigned BIT_EXEC  = 0;
  localparam int unsigned BIT_RW    = 1;
  localparam int unsigned BIT_RD    = 2;
  localparam int unsigned BIT_PRIV  = 3;
  localparam int unsigned ATTR_LO   = 4;
  localparam int unsigned ATTR_HI   = 5;
  localparam int unsigned BIT_CHG   = 7;
  localparam int unsigned BIT_REF   = 8;
  localparam int unsigned USED_W    = BIT_REF + 1;

  typedef enum logic [1:0] {
    MEM_NORMAL   = 2'd0,
    MEM_ORDERED  = 2'd1,
    MEM_NONIDEM  = 2'd2,
    MEM_TOLERANT = 2'd3
  } mem_attr_e;
endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
  import pte_acc_pkg::*;
(
  input  logic [USED_W-1:0] pte_i,
  input  logic              priv_i,
  input  logic              store_i,
  input  logic              iside_i,
  output logic              perm_ok_o
);
  logic gate_ok, data_ok, fetch_ok;

  always_comb begin
    gate_ok   = priv_i | ~pte_i[BIT_PRIV];
    data_ok   = pte_i[BIT_RW] | (pte_i[BIT_RD] & ~store_i);
    // cache-inhibited pages are never executable
    fetch_ok  = pte_i[BIT_EXEC] & ~pte_i[ATTR_HI];
    perm_ok_o = gate_ok & (iside_i ? fetch_ok : data_ok);
  end
endmodule

// File: rtl/pte_rc_eval.sv
module pte_rc_eval
  import pte_acc_pkg::*;
(
  input  logic [USED_W-1:0] pte_i,
  input  logic              store_i,
  input  logic              iside_i,
  output logic              rc_ok_o
);
  logic is_write;

  always_comb begin
    is_write = store_i & ~iside_i;
    rc_ok_o  = pte_i[BIT_REF] & (pte_i[BIT_CHG] | ~is_write);
  end
endmodule

// File: rtl/pte_result_reg.sv
module pte_result_reg
  import pte_acc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  logic      perm_ok_i,
  input  logic      rc_ok_i,
  input  mem_attr_e attr_i,
  output logic      valid_o,
  output logic      ok_o,
  output logic      perm_err_o,
  output logic      rc_err_o,
  output mem_attr_e attr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      ok_o       <= 1'b0;
      perm_err_o <= 1'b0;
      rc_err_o   <= 1'b0;
      attr_o     <= MEM_NORMAL;
    end else if (valid_i) begin
      valid_o    <= 1'b1;
      ok_o       <= perm_ok_i & rc_ok_i;
      perm_err_o <= ~perm_ok_i;
      // permission fault masks tracking fault
      rc_err_o   <= perm_ok_i & ~rc_ok_i;
      attr_o     <= attr_i;
    end else begin
      valid_o    <= 1'b0;
      ok_o       <= 1'b0;
      perm_err_o <= 1'b0;
      rc_err_o   <= 1'b0;
      attr_o     <= MEM_NORMAL;
    end
  end
endmodule

// File: rtl/pte_access_check.sv
module pte_access_check
  import pte_acc_pkg::*;
#(
  parameter int unsigned PTE_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PTE_W-1:0] pte_i,
  input  logic             priv_i,
  input  logic             store_i,
  input  logic             iside_i,
  output logic             valid_o,
  output logic             ok_o,
  output logic             perm_err_o,
  output logic             rc_err_o,
  output logic [1:0]       attr_o
);
  logic [USED_W-1:0] pte_low;
  logic              perm_ok, rc_ok;
  mem_attr_e         attr_dec, attr_q;

  assign pte_low  = pte_i[USED_W-1:0];
  assign attr_dec = mem_attr_e'(pte_i[ATTR_HI:ATTR_LO]);

  generate
    if (PTE_W > USED_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^pte_i[PTE_W-1:USED_W];
    end
  endgenerate

  pte_perm_eval u_perm (
    .pte_i    (pte_low),
    .priv_i   (priv_i),
    .store_i  (store_i),
    .iside_i  (iside_i),
    .perm_ok_o(perm_ok)
  );

  pte_rc_eval u_rc (
    .pte_i  (pte_low),
    .store_i(store_i),
    .iside_i(iside_i),
    .rc_ok_o(rc_ok)
  );

  pte_result_reg u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .perm_ok_i (perm_ok),
    .rc_ok_i   (rc_ok),
    .attr_i    (attr_dec),
    .valid_o   (valid_o),
    .ok_o      (ok_o),
    .perm_err_o(perm_err_o),
    .rc_err_o  (rc_err_o),
    .attr_o    (attr_q)
  );

  assign attr_o = attr_q;
endmodule

// File: rtl/pte_access_check_chk.sv
module pte_access_check_chk #(
  parameter int unsigned PTE_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [PTE_W-1:0] pte_i,
  input logic             priv_i,
  input logic             store_i,
  input logic             iside_i,
  input logic             valid_o,
  input logic             ok_o,
  input logic             perm_err_o,
  input logic             rc_err_o,
  input logic [1:0]       attr_o
);
  logic seen_v;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen_v <= 1'b0;
    else         seen_v <= valid_i;

  // R1
  priv_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !priv_i && pte_i[3] |=> perm_err_o);

  // R3
  fetch_ci_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && iside_i && pte_i[5] |=> perm_err_o);

  // R4
  store_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !iside_i && store_i && !pte_i[7] |=> !ok_o);

  // R4
  no_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !pte_i[8] |=> !ok_o);

  // R5
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_o, perm_err_o, rc_err_o}));

  // R5
  result_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones({ok_o, perm_err_o, rc_err_o}) == 1);

  // R6
  attr_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> attr_o == $past(pte_i[5:4]));

  // R7
  strobe_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == seen_v);

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !ok_o && !perm_err_o && !rc_err_o && attr_o == 2'd0);
endmodule

bind pte_access_check pte_access_check_chk #(.PTE_W(PTE_W)) u_chk (.*);

// File: tb/sim_pte_access_check.sv
`timescale 1ns/1ps
module sim_pte_access_check;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] pte_i = '0;
  logic        priv_i = 1'b0, store_i = 1'b0, iside_i = 1'b0;
  logic        valid_o, ok_o, perm_err_o, rc_err_o;
  logic [1:0]  attr_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pte_access_check u0 (.*);

  // {pte[15:0], priv, store, iside, ok, perm, rc}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {16'h0104, 3'b000, 3'b100},  // R2 read load ok
    {16'h0104, 3'b010, 3'b010},  // R2 read-only store denied
    {16'h0102, 3'b010, 3'b001},  // R4 store, no change bit
    {16'h0182, 3'b010, 3'b100},  // R4 store with change
    {16'h010A, 3'b000, 3'b010},  // R1 user on privileged page
    {16'h010A, 3'b100, 3'b100},  // R1 privileged passes
    {16'h0101, 3'b001, 3'b100},  // R3 fetch ok
    {16'h0121, 3'b001, 3'b010},  // R3 cache-inhibited fetch
    {16'h0100, 3'b001, 3'b010},  // R3 no exec
    {16'h0002, 3'b000, 3'b001},  // R4 no reference
    {16'h0000, 3'b000, 3'b010},  // R5 perm masks rc
    {16'h0114, 3'b000, 3'b100},  // R6 attr 1
    {16'h0134, 3'b000, 3'b100},  // R6 attr 3
    {16'h0186, 3'b011, 3'b010}   // R3 rw without exec, store ignored
  };

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act={v,ok,pe,rc,attr}=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [15:0] p, logic [2:0] c);
    valid_i = v; pte_i = {48'h0, p};
    {priv_i, store_i, iside_i} = c;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9", {valid_o, ok_o, perm_err_o, rc_err_o, attr_o}, 6'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][21:6], VEC[i][5:3]);
      @(negedge clk_i);
      // R5 R7 R6: result one edge later, attr = bits 5:4
      check("R5/R7", {valid_o, ok_o, perm_err_o, rc_err_o, attr_o},
            {1'b1, VEC[i][2:0], VEC[i][11:10]});
    end
    // R8 idle with faulting entry on inputs
    drive(1'b0, 16'h0028, 3'b001);
    @(negedge clk_i);
    check("R8", {valid_o, ok_o, perm_err_o, rc_err_o, attr_o}, 6'b0);
    // R7 single pulse then low
    drive(1'b1, 16'h0134, 3'b000);
    @(negedge clk_i);
    check("R7", {valid_o, ok_o, perm_err_o, rc_err_o, attr_o}, 6'b110011);
    drive(1'b0, 16'h0134, 3'b000);
    @(negedge clk_i);
    check("R7", {valid_o, ok_o, perm_err_o, rc_err_o, attr_o}, 6'b0);
    // R9 asynchronous reset clears outputs
    drive(1'b1, 16'h0104, 3'b000);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R9", {valid_o, ok_o, perm_err_o, rc_err_o, attr_o}, 6'b0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule